// File: doc/BRIEF.md
# Saturating Loop Accumulator

This block runs one counted loop from an audio encoder's predictor update. A start pulse captures a signed 16-bit starting value and a loop length. The block then accepts one signed difference sample per iteration over a ready/valid handshake. Each accepted sample is added to the running value, and the sum is clamped to the signed 16-bit range. Once the agreed number of samples has been taken, the block presents the final value on its result port with a one-cycle done pulse.

The datapath is built in a speculative style. The 17-bit sum and both range tests are formed in the same cycle, and two chained two-input selectors commit either the saturated bound or the raw sum. A loop-carried selector feeds the iteration body. It takes the captured starting value on the first pass and the registered feedback on every later pass, and the iteration index is handled the same way. When the loop test fails, a steering switch sends the current value to the exit register instead of to the adder.

Top module: `sat_loop_acc`

## Requirements
- R1: After synchronous reset, and until the next start, done is 0, diff_ready is 0 and result is 0. A reset during a loop abandons it.
- R2: A start pulse accepted while idle captures pred as the running value and clears the iteration index. With len = 0, done rises in the second cycle after the start cycle, and result equals pred.
- R3: When the running value plus diff is greater than 32767, the committed value is 32767 (0x7FFF).
- R4: When the running value plus diff is less than -32768, the committed value is -32768 (0x8000).
- R5: Otherwise the exact sum, computed at 17-bit signed precision, is committed. This includes sums lying exactly on either bound.
- R6: diff_ready is 1 only while a loop is active and the index is below len. An iteration advances only in a cycle where diff_valid and diff_ready are both 1, and diff is ignored in every other cycle.
- R7: Exactly len samples are accepted. Done rises one cycle after the last accepted sample and lasts one cycle.
- R8: A start pulse that arrives while a loop is active is ignored, together with its pred and len.
- R9: A start pulse in the same cycle as done is accepted and begins a new loop.
- R10: result holds its value from one done pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a loop when the block is idle |
| pred | input | 16 | Signed starting value |
| len | input | 8 | Number of iterations |
| diff | input | 16 | Signed difference sample |
| diff_valid | input | 1 | diff carries a sample |
| diff_ready | output | 1 | Block accepts a sample this cycle |
| result | output | 16 | Signed final value, held |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
Two pairs of events can fall in the same cycle. In the first, the exit that raises done coincides with a fresh start. The bench drives start in the very cycle it observes done, then checks that the second loop's len = 0 result appears two cycles later and that no done pulse is lost or duplicated. In the second, a foreign start is injected mid-loop, in a cycle where a sample handshake may also take place. The bench judges this from the final result against its own saturating model, and from the count of accepted samples, so any capture of the stray pred or len shows up at the ports.

// File: rtl/sat_acc_pkg.sv
package sat_acc_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } loop_state_e;

endpackage

// File: rtl/sal_mux2.sv
module sal_mux2 #(
  parameter int W = 16
) (
  input  logic         sel,
  input  logic [W-1:0] in0,
  input  logic [W-1:0] in1,
  output logic [W-1:0] out
);

  assign out = sel ? in1 : in0;

endmodule

// File: rtl/sal_addcmp.sv
module sal_addcmp #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] diff,
  output logic [DW:0]   sum_w,
  output logic          hi_pred,
  output logic          lo_pred
);

  localparam logic signed [DW:0] MAX_W = {2'b00, {(DW-1){1'b1}}};
  localparam logic signed [DW:0] MIN_W = {2'b11, {(DW-1){1'b0}}};

  function automatic logic [DW:0] widen_add(input logic [DW-1:0] a,
                                            input logic [DW-1:0] b);
    return {a[DW-1], a} + {b[DW-1], b};
  endfunction

  function automatic logic above_max(input logic [DW:0] s);
    return $signed(s) > MAX_W;
  endfunction

  function automatic logic below_min(input logic [DW:0] s);
    return $signed(s) < MIN_W;
  endfunction

  // both range tests work on the sum in parallel; neither waits on the other
  assign sum_w   = widen_add(acc, diff);
  assign hi_pred = above_max(sum_w);
  assign lo_pred = below_min(sum_w);

endmodule

// File: rtl/sal_commit.sv
module sal_commit #(
  parameter int DW = 16
) (
  input  logic [DW:0]   sum_w,
  input  logic          hi_pred,
  input  logic          lo_pred,
  output logic [DW-1:0] commit_val
);

  localparam logic [DW-1:0] MAX_V = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MIN_V = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] lo_stage;

  // first stage: lower bound against raw sum
  sal_mux2 #(.W(DW)) u_lo (
    .sel (lo_pred),
    .in0 (sum_w[DW-1:0]),
    .in1 (MIN_V),
    .out (lo_stage)
  );

  // second stage: upper bound wins over everything before it
  sal_mux2 #(.W(DW)) u_hi (
    .sel (hi_pred),
    .in0 (lo_stage),
    .in1 (MAX_V),
    .out (commit_val)
  );

endmodule

// File: rtl/sal_exit_switch.sv
module sal_exit_switch #(
  parameter int DW = 16
) (
  input  logic          to_exit,
  input  logic [DW-1:0] val_in,
  output logic [DW-1:0] body_val,
  output logic [DW-1:0] exit_val
);

  assign body_val = to_exit ? '0 : val_in;
  assign exit_val = to_exit ? val_in : '0;

endmodule

// File: rtl/sal_loop_ctrl.sv
module sal_loop_ctrl
  import sat_acc_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [LW-1:0] len,
  input  logic          diff_valid,
  output logic          busy,
  output logic          first,
  output logic          accept_start,
  output logic          loop_go,
  output logic          take_iter,
  output logic          exit_fire,
  output logic [LW-1:0] idx_cur,
  output logic [LW-1:0] len_q
);

  loop_state_e   state_q;
  logic          first_q;
  logic [LW-1:0] idx_q;
  logic [LW-1:0] idx_nxt;

  function automatic logic [LW-1:0] bump(input logic [LW-1:0] v);
    return v + {{(LW-1){1'b0}}, 1'b1};
  endfunction

  assign busy  = (state_q == ST_RUN);
  assign first = first_q;

  // loop-carried select for the index: zero on the first pass
  sal_mux2 #(.W(LW)) u_idx_carry (
    .sel (first_q),
    .in0 (idx_q),
    .in1 ({LW{1'b0}}),
    .out (idx_cur)
  );

  assign accept_start = !busy && start;
  assign loop_go      = busy && (idx_cur < len_q);
  assign exit_fire    = busy && !loop_go;
  assign take_iter    = loop_go && diff_valid;
  assign idx_nxt      = bump(idx_cur);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      first_q <= 1'b0;
      idx_q   <= '0;
      len_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept_start) begin
            state_q <= ST_RUN;
            first_q <= 1'b1;
            len_q   <= len;
          end
        end
        default: begin
          if (exit_fire) begin
            state_q <= ST_IDLE;
            first_q <= 1'b0;
          end else if (take_iter) begin
            idx_q   <= idx_nxt;
            first_q <= 1'b0;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/sat_loop_acc.sv
module sat_loop_acc #(
  parameter int DW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] pred,
  input  logic [LW-1:0] len,
  input  logic [DW-1:0] diff,
  input  logic          diff_valid,
  output logic          diff_ready,
  output logic [DW-1:0] result,
  output logic          done
);

  logic          busy;
  logic          first;
  logic          accept_start;
  logic          loop_go;
  logic          take_iter;
  logic          exit_fire;
  logic [LW-1:0] idx_cur;
  logic [LW-1:0] len_q;

  logic [DW-1:0] init_q;
  logic [DW-1:0] acc_q;
  logic [DW-1:0] acc_cur;
  logic [DW-1:0] body_val;
  logic [DW-1:0] exit_val;
  logic [DW:0]   sum_w;
  logic          hi_pred;
  logic          lo_pred;
  logic [DW-1:0] commit_val;
  logic [DW-1:0] result_q;
  logic          done_q;

  sal_loop_ctrl #(.LW(LW)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .len          (len),
    .diff_valid   (diff_valid),
    .busy         (busy),
    .first        (first),
    .accept_start (accept_start),
    .loop_go      (loop_go),
    .take_iter    (take_iter),
    .exit_fire    (exit_fire),
    .idx_cur      (idx_cur),
    .len_q        (len_q)
  );

  // loop-carried select for the value: captured start value on the first pass
  sal_mux2 #(.W(DW)) u_acc_carry (
    .sel (first),
    .in0 (acc_q),
    .in1 (init_q),
    .out (acc_cur)
  );

  sal_exit_switch #(.DW(DW)) u_switch (
    .to_exit  (exit_fire),
    .val_in   (acc_cur),
    .body_val (body_val),
    .exit_val (exit_val)
  );

  sal_addcmp #(.DW(DW)) u_addcmp (
    .acc     (body_val),
    .diff    (diff),
    .sum_w   (sum_w),
    .hi_pred (hi_pred),
    .lo_pred (lo_pred)
  );

  sal_commit #(.DW(DW)) u_commit (
    .sum_w      (sum_w),
    .hi_pred    (hi_pred),
    .lo_pred    (lo_pred),
    .commit_val (commit_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q   <= '0;
      acc_q    <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      if (accept_start) init_q <= pred;
      if (take_iter)    acc_q  <= commit_val;
      if (exit_fire)    result_q <= exit_val;
      done_q <= exit_fire;
    end
  end

  assign diff_ready = loop_go;
  assign result     = result_q;
  assign done       = done_q;

endmodule

// File: rtl/sal_checker.sv
module sal_checker #(
  parameter int DW = 16,
  parameter int LW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [DW-1:0] pred,
  input logic          busy,
  input logic          first,
  input logic          exit_fire,
  input logic          take_iter,
  input logic          hi_pred,
  input logic          lo_pred,
  input logic [DW:0]   sum_w,
  input logic [DW-1:0] acc_q,
  input logic [DW-1:0] init_q,
  input logic [LW-1:0] idx_cur,
  input logic [LW-1:0] len_q,
  input logic          diff_ready,
  input logic [DW-1:0] result,
  input logic          done
);

  localparam logic [DW-1:0] MAX_V = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MIN_V = {1'b1, {(DW-1){1'b0}}};

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!done && !diff_ready && result == '0));

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (first && busy && init_q == $past(pred)));

  p_clamp_hi_r3: assert property (@(posedge clk) disable iff (rst)
    (take_iter && hi_pred) |=> (acc_q == MAX_V));

  p_clamp_lo_r4: assert property (@(posedge clk) disable iff (rst)
    (take_iter && lo_pred && !hi_pred) |=> (acc_q == MIN_V));

  p_pass_r5: assert property (@(posedge clk) disable iff (rst)
    (take_iter && !hi_pred && !lo_pred) |=> (acc_q == $past(sum_w[DW-1:0])));

  p_ready_active_r6: assert property (@(posedge clk) disable iff (rst)
    diff_ready |-> busy);

  p_idx_bound_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> (idx_cur <= len_q));

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !exit_fire) |=> (busy && $stable(init_q) && $stable(len_q)));

  p_result_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

endmodule

bind sat_loop_acc sal_checker #(.DW(DW), .LW(LW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .pred       (pred),
  .busy       (busy),
  .first      (first),
  .exit_fire  (exit_fire),
  .take_iter  (take_iter),
  .hi_pred    (hi_pred),
  .lo_pred    (lo_pred),
  .sum_w      (sum_w),
  .acc_q      (acc_q),
  .init_q     (init_q),
  .idx_cur    (idx_cur),
  .len_q      (len_q),
  .diff_ready (diff_ready),
  .result     (result),
  .done       (done)
);

// File: tb/sat_loop_acc_tb_top.sv
`timescale 1ns/1ps
module sat_loop_acc_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] pred = '0;
  logic [7:0]  len = '0;
  logic [15:0] diff = '0;
  logic        diff_valid = 1'b0;
  logic        diff_ready;
  logic [15:0] result;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sat_loop_acc dut_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .pred       (pred),
    .len        (len),
    .diff       (diff),
    .diff_valid (diff_valid),
    .diff_ready (diff_ready),
    .result     (result),
    .done       (done)
  );

  function automatic int sat16(input int a, input int d);
    int s;
    s = a + d;
    if (s > 32767) return 32767;
    if (s < -32768) return -32768;
    return s;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  // p: start value, l: length, fixed/fd: constant diff, inject: stray start mid-loop
  task automatic run(input int p, input int l, input bit fixed, input int fd,
                     input bit inject, input string tag);
    int exp;
    int cnt;
    int it;
    bit got;
    @(negedge clk);
    start = 1'b1;
    pred  = p[15:0];
    len   = l[7:0];
    @(negedge clk);
    start = 1'b0;
    exp = p;
    cnt = 0;
    got = 1'b0;
    for (it = 0; it < 600; it++) begin
      start = 1'b0;
      if (done) begin
        got = 1'b1;
        break;
      end
      if (fixed) diff = fd[15:0];
      else if ($urandom % 4 == 0) diff = ($urandom % 2) ? 16'h7FFF : 16'h8000;
      else diff = $urandom;
      diff_valid = ($urandom % 4) != 0;
      if (inject && it == 2 && cnt < l) begin
        start = 1'b1;
        pred  = ~p[15:0];
        len   = 8'd0;
      end
      #0.5;
      if (diff_ready != (cnt < l))
        check(1'b0, {tag, " R6 ready"}, diff_ready, (cnt < l));
      if (diff_ready && diff_valid) begin
        exp = sat16(exp, $signed(diff));
        cnt++;
      end
      @(negedge clk);
    end
    diff_valid = 1'b0;
    check(got, {tag, " R7 done seen"}, got, 1);
    check(cnt == l, {tag, " R7 sample count"}, cnt, l);
    check($signed(result) == exp, {tag, " result"}, $signed(result), exp);
    if (l == 0) check(it == 1, {tag, " R2 len0 latency"}, it, 1);
    @(negedge clk);
    check(!done, {tag, " R7 single pulse"}, done, 0);
    check($signed(result) == exp, {tag, " R10 hold"}, $signed(result), exp);
  endtask

  initial begin
    void'($urandom(32'h5A17));
    repeat (4) @(negedge clk);
    check(!done && !diff_ready && result == 0, "R1 reset", {result, done}, 0);
    rst = 1'b0;

    run(100, 0, 1'b1, 0, 1'b0, "R2 len0");
    run(-5, 0, 1'b1, 0, 1'b0, "R2 len0 neg");
    run(32000, 1, 1'b1, 32767, 1'b0, "R3 hi");
    run(1, 4, 1'b1, 32767, 1'b0, "R3 hi repeat");
    run(-32000, 1, 1'b1, -32768, 1'b0, "R4 lo");
    run(-2, 3, 1'b1, -32768, 1'b0, "R4 lo repeat");
    run(32766, 1, 1'b1, 1, 1'b0, "R5 on upper bound");
    run(-32767, 1, 1'b1, -1, 1'b0, "R5 on lower bound");
    run(100, 5, 1'b1, -7, 1'b0, "R5 plain");
    run(1000, 6, 1'b0, 0, 1'b1, "R8 stray start");
    run(-700, 9, 1'b0, 0, 1'b1, "R8 stray start b");

    // R9: start in the cycle done is visible
    @(negedge clk);
    start = 1'b1; pred = 16'd300; len = 8'd2;
    @(negedge clk);
    start = 1'b0;
    diff_valid = 1'b1; diff = 16'd10;
    repeat (2) @(negedge clk);
    diff_valid = 1'b0;
    @(negedge clk);
    check(done && result == 16'd320, "R9 first done", $signed(result), 320);
    start = 1'b1; pred = 16'hFFF0; len = 8'd0;
    @(negedge clk);
    start = 1'b0;
    check(!done, "R9 gap", done, 0);
    @(negedge clk);
    check(done && $signed(result) == -16, "R9 second done", $signed(result), -16);

    // R10: idle with valid toggling leaves result alone
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      diff_valid = k[0]; diff = 16'h1234;
      #0.5;
      check(!diff_ready && $signed(result) == -16, "R10 idle hold", $signed(result), -16);
    end
    diff_valid = 1'b0;

    for (int r = 0; r < 40; r++) begin
      int rp;
      int rl;
      rp = $signed(16'($urandom));
      rl = $urandom % 16;
      run(rp, rl, 1'b0, 0, (r % 5) == 0, "R5 random");
    end

    // R1: reset in the middle of a loop
    @(negedge clk);
    start = 1'b1; pred = 16'd77; len = 8'd10;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!done && !diff_ready && result == 0, "R1 mid-loop reset", {result, diff_ready}, 0);
    rst = 1'b0;
    run(-1234, 3, 1'b1, -1, 1'b0, "R1 after reset");

    finish_run();
  end

endmodule